// File: doc/BRIEF.md
# Rotated and Mirrored Scan Parameter Calculator

This block converts a frame-buffer geometry into the values a generic two-dimensional, double-indexed DMA engine needs to read the frame in one of eight orientations. The orientations are four rotations, each with or without a horizontal mirror. A request carries the following:

- the buffer base address
- the visible width and height in pixels
- the virtual line width
- horizontal and vertical scale factors
- an element size code
- a rotation code
- a mirror flag

The block answers with these outputs:

- the first address and the last address of the scan
- the element count per frame and the frame count
- a signed element index and a signed frame index
- a flag that asks the DMA for double-indexed addressing

The address of pixel (x, y) is base + (y·V·Ys + x·Xs)·E. Here V is the effective virtual width, Xs and Ys are the effective scales, and E is the element size in bytes. An index that moves the engine from pixel s to pixel d equals addr(d) − addr(s) − E + 1. The calculation runs over several cycles, and one shared multiplier serves every product. A one-cycle done pulse marks the moment the registered outputs become valid.

Top module: `scan_param_calc`

## Requirements
- R1: The start and end addresses select the scan corners listed below, where W1 = W−1 and H1 = H−1. Every address sum wraps modulo 2^32.

  | rot | mirror | start | end |
  |-----|--------|-------|-----|
  | 0 | 0 | (0,0) | (W1,H1) |
  | 0 | 1 | (W1,0) | (0,H1) |
  | 1 | 0 | (0,H1) | (W1,0) |
  | 1 | 1 | (W1,H1) | (0,0) |
  | 2 | 0 | (W1,H1) | (0,0) |
  | 2 | 1 | (0,H1) | (W1,0) |
  | 3 | 0 | (W1,0) | (0,H1) |
  | 3 | 1 | (0,0) | (W1,H1) |

- R2: The element index is the index of one step between pixels (source→destination):

  | rot | mirror 0 | mirror 1 |
  |-----|----------|----------|
  | 0 | (0,0)→(1,0) | (1,0)→(0,0) |
  | 1 | (0,1)→(0,0) | (0,1)→(0,0) |
  | 2 | (1,0)→(0,0) | (0,0)→(1,0) |
  | 3 | (0,0)→(0,1) | (0,0)→(0,1) |

  It is output as a signed 16-bit value.
- R3: The frame index is a signed 32-bit value, indexed from source to destination:

  | rot | mirror 0 | mirror 1 |
  |-----|----------|----------|
  | 0 | (W1,0)→(0,1) | (0,0)→(W1,1) |
  | 1 | (0,0)→(1,H1) | (1,0)→(0,H1) |
  | 2 | (0,1)→(W1,0) | (W1,1)→(0,0) |
  | 3 | (1,H1)→(0,0) | (0,H1)→(1,0) |

- R4: A virtual width of 0 means that V = W. A scale of 0 is treated as a scale of 1.
- R5: If the effective virtual width is smaller than W, err is raised.
- R6: For rotation codes 0 and 2 the element count is W and the frame count is H. For codes 1 and 3 the two counts are swapped.
- R7: dbl_idx is 1 exactly when at least one of these is nonzero: the rotation code, the mirror flag, the raw virtual width, or either raw scale.
- R8: The element size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, and 3 is invalid. The rotation code is 0, 1, 2 or 3, meaning 0°, 90°, 180° and 270°; codes 4 to 7 are invalid. An invalid code of either kind raises err.
- R9: If the element index does not fit in the range −32768 to 32767, err is raised.
- R10: The edge that samples start while the block is idle latches all inputs. done is high for exactly one cycle, in the cycle that follows the fourth rising edge after that edge. start is ignored while a calculation is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (sampled when idle) |
| base_addr | input | 32 | Frame buffer base address |
| pix_w | input | 16 | Visible width W |
| pix_h | input | 16 | Visible height H |
| line_w | input | 16 | Virtual line width (0: use W) |
| x_scale | input | 8 | Horizontal scale (0: 1) |
| y_scale | input | 8 | Vertical scale (0: 1) |
| esize_code | input | 2 | Element size code |
| rot_code | input | 3 | Rotation code |
| mirror | input | 1 | Mirror flag |
| addr_first | output | 32 | First scan address |
| addr_last | output | 32 | Last scan address |
| elem_cnt | output | 16 | Elements per frame |
| frame_cnt | output | 16 | Frame count |
| elem_idx | output | 16 | Signed element index |
| frame_idx | output | 32 | Signed frame index |
| dbl_idx | output | 1 | Double-indexed mode request |
| done | output | 1 | One-cycle result-valid pulse |
| err | output | 1 | Parameter error, valid with done |

## Verification
The conditions that are hardest to reach from the ports are the element index sitting exactly at its signed 16-bit limit and the same index crossing that limit by one. Both appear only for the rotations whose element step runs down a column. There the index is the negated line stride, so the bench places a virtual width of 32768 and then 32769 under rotation code 1. The bench also sweeps all eight orientations across every element size and several scaled geometries. Finally, it holds start high while the base address changes in the middle of a calculation, to show that the inputs latched at the start are the ones the result uses.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LINE = 3'd1,
    ST_ACOL = 3'd2,
    ST_BROW = 3'd3,
    ST_FIN  = 3'd4
  } scan_state_t;

  // log2 of the element size in bytes; the invalid code maps to 0
  function automatic logic [1:0] esize_shift(input logic [1:0] code);
    return (code == 2'd3) ? 2'd0 : code;
  endfunction

  // a zero factor stands for one
  function automatic logic [7:0] nz_scale(input logic [7:0] s);
    return (s == 8'd0) ? 8'd1 : s;
  endfunction

  // true when a 32-bit two's complement value fits in 16 bits
  function automatic logic fits_s16(input logic [31:0] v);
    return (v[31:15] == 17'h00000) || (v[31:15] == 17'h1FFFF);
  endfunction
endpackage

// File: rtl/scan_mul.sv
module scan_mul #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic [DW-1:0] prod
);
  // low half of the product: all address math is modulo 2^DW
  assign prod = op_a * op_b;
endmodule

// File: rtl/scan_corner_table.sv
module scan_corner_table #(
  parameter int AW = 32
) (
  input  logic [1:0]    rot,
  input  logic          mir,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] col_span,   // (W-1) * pixel step
  input  logic [AW-1:0] row_span,   // (H-1) * line stride
  input  logic [AW-1:0] pix_step,   // xscale * esize
  input  logic [AW-1:0] line_step,  // vwidth * yscale * esize
  input  logic [AW-1:0] esize,
  output logic [AW-1:0] first_a,
  output logic [AW-1:0] last_a,
  output logic [AW-1:0] ei_full,
  output logic [AW-1:0] fi_full
);
  logic [AW-1:0] first_off, last_off, ei_raw, fi_raw;
  logic [AW-1:0] adj;

  assign adj = esize - 1'b1;

  always_comb begin
    first_off = '0;
    last_off  = '0;
    ei_raw    = '0;
    fi_raw    = '0;
    unique case ({rot, mir})
      3'b000: begin first_off = '0;                  last_off = col_span + row_span;
                    ei_raw = pix_step;               fi_raw = line_step - col_span; end
      3'b001: begin first_off = col_span;            last_off = row_span;
                    ei_raw = -pix_step;              fi_raw = col_span + line_step; end
      3'b010: begin first_off = row_span;            last_off = col_span;
                    ei_raw = -line_step;             fi_raw = pix_step + row_span; end
      3'b011: begin first_off = col_span + row_span; last_off = '0;
                    ei_raw = -line_step;             fi_raw = row_span - pix_step; end
      3'b100: begin first_off = col_span + row_span; last_off = '0;
                    ei_raw = -pix_step;              fi_raw = col_span - line_step; end
      3'b101: begin first_off = row_span;            last_off = col_span;
                    ei_raw = pix_step;               fi_raw = -col_span - line_step; end
      3'b110: begin first_off = col_span;            last_off = row_span;
                    ei_raw = line_step;              fi_raw = -pix_step - row_span; end
      default: begin first_off = '0;                 last_off = col_span + row_span;
                    ei_raw = line_step;              fi_raw = pix_step - row_span; end
    endcase
  end

  assign first_a = base + first_off;
  assign last_a  = base + last_off;
  assign ei_full = ei_raw - adj;
  assign fi_full = fi_raw - adj;
endmodule

// File: rtl/scan_param_calc.sv
module scan_param_calc
  import scan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [DW-1:0] pix_w,
  input  logic [DW-1:0] pix_h,
  input  logic [DW-1:0] line_w,
  input  logic [SW-1:0] x_scale,
  input  logic [SW-1:0] y_scale,
  input  logic [1:0]    esize_code,
  input  logic [2:0]    rot_code,
  input  logic          mirror,
  output logic [AW-1:0] addr_first,
  output logic [AW-1:0] addr_last,
  output logic [DW-1:0] elem_cnt,
  output logic [DW-1:0] frame_cnt,
  output logic [15:0]   elem_idx,
  output logic [AW-1:0] frame_idx,
  output logic          dbl_idx,
  output logic          done,
  output logic          err
);
  scan_state_t state;

  // latched request
  logic [AW-1:0] cfg_base;
  logic [DW-1:0] cfg_w, cfg_h, cfg_vw;
  logic [SW-1:0] cfg_xs, cfg_ys;
  logic [1:0]    cfg_esz;
  logic [2:0]    cfg_rot;
  logic          cfg_mir;

  // intermediate products
  logic [AW-1:0] line_q, col_q, row_q;

  // named internal events
  logic          take_req;
  logic          vw_short;
  logic          code_bad;
  logic [DW-1:0] vw_eff;
  logic [1:0]    sh;
  logic [AW-1:0] esize_b, pix_step;
  logic [AW-1:0] mul_a, mul_b, mul_p;
  logic [AW-1:0] t_first, t_last, t_ei, t_fi;

  assign take_req = (state == ST_IDLE) && start;
  assign vw_eff   = (cfg_vw == '0) ? cfg_w : cfg_vw;
  assign vw_short = vw_eff < cfg_w;
  assign code_bad = (cfg_esz == 2'd3) || cfg_rot[2];
  assign sh       = esize_shift(cfg_esz);
  assign esize_b  = AW'(1) << sh;
  assign pix_step = AW'(nz_scale(cfg_xs)) << sh;

  // operand steering for the one shared multiplier
  always_comb begin
    unique case (state)
      ST_LINE: begin mul_a = AW'(vw_eff);          mul_b = AW'(nz_scale(cfg_ys)); end
      ST_ACOL: begin mul_a = AW'(cfg_w) - 1'b1;    mul_b = pix_step;              end
      ST_BROW: begin mul_a = AW'(cfg_h) - 1'b1;    mul_b = line_q;                end
      default: begin mul_a = '0;                   mul_b = '0;                    end
    endcase
  end

  scan_mul #(.DW(AW)) u_mul (
    .op_a (mul_a),
    .op_b (mul_b),
    .prod (mul_p)
  );

  scan_corner_table #(.AW(AW)) u_table (
    .rot       (cfg_rot[1:0]),
    .mir       (cfg_mir),
    .base      (cfg_base),
    .col_span  (col_q),
    .row_span  (row_q),
    .pix_step  (pix_step),
    .line_step (line_q),
    .esize     (esize_b),
    .first_a   (t_first),
    .last_a    (t_last),
    .ei_full   (t_ei),
    .fi_full   (t_fi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cfg_base <= '0; cfg_w  <= '0; cfg_h  <= '0; cfg_vw <= '0;
      cfg_xs   <= '0; cfg_ys <= '0; cfg_esz <= '0; cfg_rot <= '0; cfg_mir <= 1'b0;
      line_q   <= '0; col_q  <= '0; row_q  <= '0;
      addr_first <= '0; addr_last <= '0; elem_cnt <= '0; frame_cnt <= '0;
      elem_idx <= '0; frame_idx <= '0; dbl_idx <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (take_req) begin
          cfg_base <= base_addr; cfg_w <= pix_w; cfg_h <= pix_h; cfg_vw <= line_w;
          cfg_xs <= x_scale; cfg_ys <= y_scale; cfg_esz <= esize_code;
          cfg_rot <= rot_code; cfg_mir <= mirror;
          state <= ST_LINE;
        end
        ST_LINE: begin line_q <= mul_p << sh; state <= ST_ACOL; end
        ST_ACOL: begin col_q  <= mul_p;       state <= ST_BROW; end
        ST_BROW: begin row_q  <= mul_p;       state <= ST_FIN;  end
        ST_FIN: begin
          addr_first <= t_first;
          addr_last  <= t_last;
          elem_idx   <= t_ei[15:0];
          frame_idx  <= t_fi;
          elem_cnt   <= cfg_rot[0] ? cfg_h : cfg_w;
          frame_cnt  <= cfg_rot[0] ? cfg_w : cfg_h;
          dbl_idx    <= (cfg_rot != 3'd0) || cfg_mir || (cfg_vw != '0) ||
                        (cfg_xs != '0) || (cfg_ys != '0);
          err        <= code_bad || vw_short || !fits_s16(t_ei);
          done       <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_AFTER_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(state == ST_FIN)); // R10
  AST_BAD_CODE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && code_bad) |-> err); // R8
  AST_SHORT_LINE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && vw_short) |-> err); // R5
  AST_COUNT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_rot[0]) |-> (elem_cnt == cfg_h && frame_cnt == cfg_w)); // R6
  AST_PLAIN_NO_DBL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_rot == 3'd0 && !cfg_mir && cfg_vw == '0 && cfg_xs == '0 && cfg_ys == '0)
      |-> !dbl_idx); // R7
endmodule

// File: tb/scan_param_calc_tb.sv
module scan_param_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] pix_w = '0, pix_h = '0, line_w = '0;
  logic [7:0]  x_scale = '0, y_scale = '0;
  logic [1:0]  esize_code = '0;
  logic [2:0]  rot_code = '0;
  logic        mirror = 1'b0;
  logic [31:0] addr_first, addr_last, frame_idx;
  logic [15:0] elem_cnt, frame_cnt, elem_idx;
  logic        dbl_idx, done, err;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  scan_param_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .pix_w(pix_w), .pix_h(pix_h), .line_w(line_w), .x_scale(x_scale),
    .y_scale(y_scale), .esize_code(esize_code), .rot_code(rot_code),
    .mirror(mirror), .addr_first(addr_first), .addr_last(addr_last),
    .elem_cnt(elem_cnt), .frame_cnt(frame_cnt), .elem_idx(elem_idx),
    .frame_idx(frame_idx), .dbl_idx(dbl_idx), .done(done), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  // model state for the current request
  logic [31:0] m_base, m_vw, m_xs, m_ys, m_es;

  function automatic logic [31:0] pa(input logic [31:0] x, input logic [31:0] y);
    return m_base + (y * m_vw * m_ys + x * m_xs) * m_es;
  endfunction

  function automatic logic [31:0] stp(input logic [31:0] sx, input logic [31:0] sy,
                                      input logic [31:0] dx, input logic [31:0] dy);
    return pa(dx, dy) - pa(sx, sy) - m_es + 32'd1;
  endfunction

  task automatic run(input logic [31:0] b, input int w, input int h, input int vw,
                     input int xs, input int ys, input int ec, input int rc,
                     input bit mr, input bit hold);
    int n;
    logic [31:0] w1, h1, ef, fi, t0, t1;
    logic exp_err;
    @(negedge clk);
    base_addr = b; pix_w = 16'(w); pix_h = 16'(h); line_w = 16'(vw);
    x_scale = 8'(xs); y_scale = 8'(ys); esize_code = 2'(ec); rot_code = 3'(rc);
    mirror = mr; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (!hold) start = 1'b0;
    if (hold) base_addr = ~b;
    n = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk);
      if (hold && n == 2) start = 1'b0;
      if (done || n > 12) break;
    end
    chk("R10 latency", 32'(n), 32'd4);
    // model
    m_base = b;
    m_vw = (vw == 0) ? 32'(w) : 32'(vw);
    m_xs = (xs == 0) ? 32'd1 : 32'(xs);
    m_ys = (ys == 0) ? 32'd1 : 32'(ys);
    m_es = (ec == 0) ? 32'd1 : (ec == 1) ? 32'd2 : 32'd4;
    w1 = 32'(w) - 1; h1 = 32'(h) - 1;
    case ({rc[1:0], mr})
      3'b000: begin t0 = pa(0,0);   t1 = pa(w1,h1); ef = stp(0,0,1,0); fi = stp(w1,0,0,1); end
      3'b001: begin t0 = pa(w1,0);  t1 = pa(0,h1);  ef = stp(1,0,0,0); fi = stp(0,0,w1,1); end
      3'b010: begin t0 = pa(0,h1);  t1 = pa(w1,0);  ef = stp(0,1,0,0); fi = stp(0,0,1,h1); end
      3'b011: begin t0 = pa(w1,h1); t1 = pa(0,0);   ef = stp(0,1,0,0); fi = stp(1,0,0,h1); end
      3'b100: begin t0 = pa(w1,h1); t1 = pa(0,0);   ef = stp(1,0,0,0); fi = stp(0,1,w1,0); end
      3'b101: begin t0 = pa(0,h1);  t1 = pa(w1,0);  ef = stp(0,0,1,0); fi = stp(w1,1,0,0); end
      3'b110: begin t0 = pa(w1,0);  t1 = pa(0,h1);  ef = stp(0,0,0,1); fi = stp(1,h1,0,0); end
      default: begin t0 = pa(0,0);  t1 = pa(w1,h1); ef = stp(0,0,0,1); fi = stp(0,h1,1,0); end
    endcase
    exp_err = (ec == 3) || (rc > 3) || (m_vw < 32'(w)) ||
              !($signed(ef) >= -32768 && $signed(ef) <= 32767);
    chk("R5/R8/R9 err", 32'(err), 32'(exp_err));
    if (!exp_err) begin
      chk("R1 first", addr_first, t0);
      chk("R1 last", addr_last, t1);
      chk("R2 elem_idx", {{16{elem_idx[15]}}, elem_idx}, ef);
      chk("R3 frame_idx", frame_idx, fi);
      chk("R6 elem_cnt", 32'(elem_cnt), rc[0] ? 32'(h) : 32'(w));
      chk("R6 frame_cnt", 32'(frame_cnt), rc[0] ? 32'(w) : 32'(h));
      chk("R7 dbl_idx", 32'(dbl_idx),
          32'((rc != 0) || mr || (vw != 0) || (xs != 0) || (ys != 0)));
    end
    @(posedge clk);
    @(negedge clk);
    chk("R10 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset done", 32'(done), 32'd0);
    chk("R10 reset err", 32'(err), 32'd0);
    chk("R6 reset elem_cnt", 32'(elem_cnt), 32'd0);
    rst_n = 1'b1;

    // sweep of all orientations, sizes and a few geometries (R1 R2 R3 R6 R7)
    for (int r = 0; r < 4; r++)
      for (int m = 0; m < 2; m++)
        for (int e = 0; e < 3; e++) begin
          run(32'h1000_0000, 3, 2, 0, 0, 0, e, r, m[0], 1'b0);
          run(32'h0000_4000, 5, 4, 8, 2, 3, e, r, m[0], 1'b0);
          run(32'h2000_0100, 1, 1, 0, 1, 0, e, r, m[0], 1'b0);
        end
    // R4: zero virtual width and zero scales act as W and 1
    run(32'h0000_8000, 7, 3, 0, 0, 0, 1, 0, 1'b0, 1'b0);
    run(32'h0000_8000, 7, 3, 7, 1, 1, 1, 0, 1'b0, 1'b0);
    // R1: wrap modulo 2^32
    run(32'hFFFF_FFF0, 8, 4, 0, 0, 0, 2, 2, 1'b0, 1'b0);
    // R5: short virtual line
    run(32'h0, 4, 2, 3, 0, 0, 0, 0, 1'b0, 1'b0);
    // R8: invalid codes
    run(32'h0, 4, 2, 0, 0, 0, 3, 0, 1'b0, 1'b0);
    run(32'h0, 4, 2, 0, 0, 0, 0, 5, 1'b0, 1'b0);
    run(32'h0, 4, 2, 0, 0, 0, 0, 7, 1'b1, 1'b0);
    // R9: element index exactly at the limit, then one past it
    run(32'h0, 4, 2, 32768, 0, 0, 0, 1, 1'b0, 1'b0);
    run(32'h0, 4, 2, 32769, 0, 0, 0, 1, 1'b0, 1'b0);
    run(32'h0, 4, 2, 1000, 0, 20, 2, 3, 1'b1, 1'b0);
    // R10: start held and inputs changed during the calculation
    run(32'h0300_0000, 6, 5, 0, 2, 2, 1, 3, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule